// File: doc/BRIEF.md
# GPIO Controller with Interrupt Polarity

This block is a memory-mapped general-purpose I/O port with thirty-two lines. A simple register bus reaches it: an address, a write enable and write data are sampled on the rising clock edge, and read data is a combinational function of the current address. Software uses a direction register to choose, line by line, whether the pin is an input or an output. The output value of each line sits in an output-data register. That register can be written as a whole, or changed one bit at a time through a set port and a clear port. The pin inputs are synchronized before software reads them or the interrupt logic uses them.

The lower sixteen lines also feed active-high interrupt requests to an upstream interrupt controller. The output-data bit of each line has a second job: it selects the interrupt polarity. A value of 0 asks for a high level or a rising edge. A value of 1 asks for a low level or a falling edge, and that request is inverted so that the upstream controller still sees it as active-high. A separate per-line mode bit overrides the polarity and makes the line pulse on every change of its input. Masking and acknowledge belong to the upstream controller.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the direction, output-data and interrupt-mode registers and the input synchronizer to zero. After reset every output enable is 0, every read of a mapped offset returns 0 and every interrupt output is 0.
- R2: When direction bit i is 1, pinOe[i] is 1. When it is 0, pinOe[i] is 0. pinOut always presents the output-data register.
- R3: A write to offset 0x18 sets each output-data bit where the write data has a 1. A write to offset 0x20 clears each output-data bit where the write data has a 1. Bits whose write-data bit is 0 keep their value. A write to offset 0x10 loads the whole register.
- R4: A read of offset 0x08 returns the pin inputs after two clock stages. A pin change applied before a rising edge is not visible after that edge, and is visible after the next one.
- R5: When interrupt-mode bit i (i < 16) is 0, irqOut[i] equals the synchronized input i XOR output-data bit i. This holds in the same cycle in which either of them changes, so a polarity write that lands together with an input change produces no pulse.
- R6: When interrupt-mode bit i (i < 16) is 1, irqOut[i] is 1 for exactly one clock cycle after each change of synchronized input i. This holds in both directions and does not depend on output-data bit i.
- R7: Only lines 0 to 15 have interrupt outputs. Changes on inputs 16 to 31 leave irqOut unchanged.
- R8: Reads of offsets 0x00, 0x10 and 0x30 return the direction, output-data and interrupt-mode registers. Reads of 0x18 and 0x20 return 0.
- R9: A write to an unmapped offset (for example 0x04) or to the input offset 0x08 changes no register and no output. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write enable, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address |
| pinIn | input | 32 | Pin input values, asynchronous |
| pinOut | output | 32 | Pin output values |
| pinOe | output | 32 | Pin output enables |
| irqOut | output | 16 | Active-high interrupt requests to the upstream controller |

## Verification
A bus write to the set port can move a line's polarity bit on the same clock edge at which a new value of that line reaches the end of the synchronizer. The bench provokes this by changing a pin and then timing a set-port write so that it lands on the second rising edge after the change. For a level line, the interrupt output must stay low through both cycles, because the new input XOR the new polarity is still 0. For a both-edges line, the same collision must still give exactly one pulse of one cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Byte offsets of the register file
  localparam int OFS_DIR  = 'h00;
  localparam int OFS_IN   = 'h08;
  localparam int OFS_OUT  = 'h10;
  localparam int OFS_SET  = 'h18;
  localparam int OFS_CLR  = 'h20;
  localparam int OFS_MODE = 'h30;

  // Write strobes from the decoder to the datapath
  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic wrSet;
    logic wrClr;
    logic wrMode;
  } regStrobe_t;

  // Read-back source selection
  typedef enum logic [2:0] {
    RD_NONE,
    RD_DIR,
    RD_IN,
    RD_OUT,
    RD_MODE
  } rdSel_t;

endpackage

// File: rtl/gpio_irq_ctrl_dec.sv
module gpio_irq_ctrl_dec
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);

  // Full-width address compare: aliases of an offset do not hit
  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    case (busAddr)
      ADDR_W'(OFS_DIR): begin
        rdSel        = RD_DIR;
        strobe.wrDir = busWe;
      end
      ADDR_W'(OFS_IN): begin
        rdSel = RD_IN;   // input register is read-only, writes dropped
      end
      ADDR_W'(OFS_OUT): begin
        rdSel        = RD_OUT;
        strobe.wrOut = busWe;
      end
      ADDR_W'(OFS_SET): begin
        strobe.wrSet = busWe;   // reads return zero
      end
      ADDR_W'(OFS_CLR): begin
        strobe.wrClr = busWe;   // reads return zero
      end
      ADDR_W'(OFS_MODE): begin
        rdSel         = RD_MODE;
        strobe.wrMode = busWe;
      end
      default: begin
        strobe = '0;
        rdSel  = RD_NONE;
      end
    endcase
  end

endmodule

// File: rtl/gpio_irq_ctrl_dp.sv
module gpio_irq_ctrl_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int NUM_IRQ     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  rdSel_t              rdSel,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdata,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_IRQ-1:0]  irqOut
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncChain;
  logic [NUM_PINS-1:0] syncIn;
  logic [NUM_IRQ-1:0]  prevIn;
  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] outReg;
  logic [NUM_PINS-1:0] modeReg;

  // Input synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        syncChain[s] <= syncChain[s-1];
      end
    end
  end

  assign syncIn = syncChain[LAST_STAGE];

  // Last synchronized value of the interrupt-capable lines
  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn[NUM_IRQ-1:0];
  end

  // Control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg  <= '0;
      outReg  <= '0;
      modeReg <= '0;
    end else begin
      if (strobe.wrDir)  dirReg  <= wdata;
      if (strobe.wrMode) modeReg <= wdata;
      if (strobe.wrOut)      outReg <= wdata;
      else if (strobe.wrSet) outReg <= outReg | wdata;
      else if (strobe.wrClr) outReg <= outReg & ~wdata;
    end
  end

  assign pinOut = outReg;
  assign pinOe  = dirReg;

  // Per-line interrupt request: the output bit doubles as polarity,
  // the mode bit switches to change detection on both edges
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic lvlReq;
    logic edgeReq;
    assign lvlReq    = syncIn[i] ^ outReg[i];
    assign edgeReq   = syncIn[i] ^ prevIn[i];
    assign irqOut[i] = modeReg[i] ? edgeReq : lvlReq;
  end

  // Read-back mux
  always_comb begin
    case (rdSel)
      RD_DIR:  rdata = dirReg;
      RD_IN:   rdata = syncIn;
      RD_OUT:  rdata = outReg;
      RD_MODE: rdata = modeReg;
      default: rdata = '0;
    endcase
  end

  AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSet |=> ((outReg & $past(wdata)) == $past(wdata))); // R3

  AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrClr |=> ((outReg & $past(wdata)) == '0)); // R3

  AST_SETCLR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrSet || strobe.wrClr) |=>
      ((outReg & ~$past(wdata)) == ($past(outReg) & ~$past(wdata)))); // R3

  AST_EDGE_QUIET_WHEN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(syncIn) && $stable(modeReg)) |->
      ((irqOut & modeReg[NUM_IRQ-1:0]) == '0)); // R6

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_PINS    = 32,
  parameter int NUM_IRQ     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_IRQ-1:0]  irqOut
);

  regStrobe_t strobe;
  rdSel_t     rdSel;

  gpio_irq_ctrl_dec #(
    .ADDR_W (ADDR_W)
  ) i_dec (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_irq_ctrl_dp #(
    .NUM_PINS    (NUM_PINS),
    .NUM_IRQ     (NUM_IRQ),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdSel  (rdSel),
    .wdata  (busWdata),
    .pinIn  (pinIn),
    .rdata  (busRdata),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqOut (irqOut)
  );

  logic addrMapped;
  logic addrSetClr;
  assign addrMapped = busAddr inside {ADDR_W'(OFS_DIR), ADDR_W'(OFS_OUT),
                                      ADDR_W'(OFS_SET), ADDR_W'(OFS_CLR),
                                      ADDR_W'(OFS_MODE)};
  assign addrSetClr = (busAddr == ADDR_W'(OFS_SET)) || (busAddr == ADDR_W'(OFS_CLR));

  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    addrSetClr |-> (busRdata == '0)); // R8

  AST_DEAD_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !addrMapped) |=> ($stable(pinOut) && $stable(pinOe))); // R9

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic [15:0] irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycles   = 0;

  always #4 clk = ~clk;   // 125 MHz

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      report();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = 8'h3c;
  endtask

  task automatic busRead(input string req, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic stepN(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; pinIn = '0;
    stepN(3);
    rstN = 1'b1;
  endtask

  // {isWrite, addr, data}: a write applies data, a read expects data
  localparam int NVEC = 18;
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 32'h0000_FFFF},
    {1'b0, 8'h00, 32'h0000_FFFF},
    {1'b1, 8'h10, 32'hA5A5_0F0F},
    {1'b0, 8'h10, 32'hA5A5_0F0F},
    {1'b1, 8'h18, 32'h0000_00F0},
    {1'b0, 8'h10, 32'hA5A5_0FFF},
    {1'b1, 8'h20, 32'hA000_000F},
    {1'b0, 8'h10, 32'h05A5_0FF0},
    {1'b0, 8'h18, 32'h0000_0000},
    {1'b0, 8'h20, 32'h0000_0000},
    {1'b1, 8'h30, 32'h1234_5678},
    {1'b0, 8'h30, 32'h1234_5678},
    {1'b1, 8'h04, 32'hFFFF_FFFF},
    {1'b0, 8'h04, 32'h0000_0000},
    {1'b1, 8'h08, 32'hFFFF_FFFF},
    {1'b0, 8'h08, 32'h0000_0000},
    {1'b0, 8'h10, 32'h05A5_0FF0},
    {1'b0, 8'h00, 32'h0000_FFFF}
  };

  initial begin
    @(negedge clk);
    doReset();

    // R1: reset state
    busRead("R1 dir", 8'h00, 32'h0);
    busRead("R1 out", 8'h10, 32'h0);
    busRead("R1 mode", 8'h30, 32'h0);
    check("R1 oe", pinOe, 32'h0);
    check("R1 irq", {16'h0, irqOut}, 32'h0);

    // R2 R3 R8 R9: register table
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][40]) busWrite(VEC[v][39:32], VEC[v][31:0]);
      else busRead("R3/R8/R9 table", VEC[v][39:32], VEC[v][31:0]);
    end
    check("R2 oe", pinOe, 32'h0000_FFFF);
    check("R2 out", pinOut, 32'h05A5_0FF0);
    busWrite(8'h04, 32'h0);
    check("R9 out after dead write", pinOut, 32'h05A5_0FF0);
    check("R9 oe after dead write", pinOe, 32'h0000_FFFF);

    // R1: reset again clears everything
    doReset();
    busRead("R1 out after reset", 8'h10, 32'h0);
    check("R1 oe after reset", pinOe, 32'h0);

    // R4: two-stage input
    pinIn = 32'h8000_0001;
    @(negedge clk);
    busRead("R4 one edge", 8'h08, 32'h0);
    @(negedge clk);
    busRead("R4 two edges", 8'h08, 32'h8000_0001);

    // R5: level, polarity from output bit, active-high to upstream
    check("R5 high level", {16'h0, irqOut}, 32'h0001);
    busWrite(8'h18, 32'h1);
    check("R5 inverted high", {31'h0, irqOut[0]}, 32'h0);
    pinIn[0] = 1'b0;
    stepN(2);
    check("R5 low level asserted", {31'h0, irqOut[0]}, 32'h1);

    // R6: both edges, output bit ignored
    busWrite(8'h30, 32'h2);
    busWrite(8'h18, 32'h2);
    pinIn[1] = 1'b1;
    @(negedge clk);
    check("R6 rise not yet", {31'h0, irqOut[1]}, 32'h0);
    @(negedge clk);
    check("R6 rise pulse", {31'h0, irqOut[1]}, 32'h1);
    @(negedge clk);
    check("R6 rise pulse ends", {31'h0, irqOut[1]}, 32'h0);
    pinIn[1] = 1'b0;
    stepN(2);
    check("R6 fall pulse", {31'h0, irqOut[1]}, 32'h1);
    @(negedge clk);
    check("R6 fall pulse ends", {31'h0, irqOut[1]}, 32'h0);

    // R7: upper lines make no interrupt
    pinIn[20] = 1'b1;
    stepN(3);
    check("R7 upper line", {16'h0, irqOut}, 32'h0001);

    // R5: polarity write lands together with input change on line 2
    pinIn[2] = 1'b1;
    @(negedge clk);
    check("R5 collide before", {31'h0, irqOut[2]}, 32'h0);
    busWrite(8'h18, 32'h4);
    check("R5 collide edge", {31'h0, irqOut[2]}, 32'h0);
    @(negedge clk);
    check("R5 collide after", {31'h0, irqOut[2]}, 32'h0);

    // R6: same collision on a both-edges line (line 3)
    busWrite(8'h30, 32'hA);
    pinIn[3] = 1'b1;
    @(negedge clk);
    busWrite(8'h18, 32'h8);
    check("R6 collide pulse", {31'h0, irqOut[3]}, 32'h1);
    @(negedge clk);
    check("R6 collide pulse ends", {31'h0, irqOut[3]}, 32'h0);

    report();
    $finish;
  end

endmodule